// File: doc/BRIEF.md
# Dual-Shape Two-Port RAM

This block is a 4608-bit memory with a write-only port and a read-only port. Each port runs on its own rising-edge clock. Each port picks its organisation at run time with a two-bit shape code: 512 words of 9 bits or 256 words of 18 bits. Both ports use an 18-bit data bus and a 9-bit address bus. Both shapes address one shared storage array through a fixed mapping, so data written in one shape can be read back in the other.

The read result is held in an output register, which loads on the read-clock edge that samples the address. A pipeline select adds one more register stage behind it. The enables are active low by default; a parameter per port makes either one active high. One active-low reset does three things. It clears both output registers to zero, and it blocks writes and reads. It does not change the stored words.

Top module: `dual_shape_ram`

## Requirements
- R1: Shape code 2'b01 selects 512×9 and shape code 2'b10 selects 256×18, independently for the write port (`wrShape`) and the read port (`rdShape`).
- R2: A 9-bit write stores `wrData[8:0]` at `wrAddr`. An 18-bit write stores all of `wrData` at word `wrAddr[7:0]`, and `wrAddr[8]` has no effect.
- R3: The 18-bit word n holds 9-bit word 2n in bits [8:0] and 9-bit word 2n+1 in bits [17:9], whichever shape wrote the data.
- R4: A 9-bit read returns the word in `rdData[8:0]` and zero in `rdData[17:9]`.
- R5: With `pipeSel` low, read data is on `rdData` after the `rdClk` edge that samples the address. With `pipeSel` high, it appears one `rdClk` edge later, and the output keeps its former value until then.
- R6: With the default parameters both enables are active low. With `WR_EN_HIGH`=1 or `RD_EN_HIGH`=1, the matching enable is active high, and a low level on it starts no access.
- R7: A reserved shape code (2'b00 or 2'b11) on a port makes it do nothing: a write changes no stored word, and a read leaves `rdData` unchanged.
- R8: While `rstN` is low, `rdData` is zero and writes are blocked. Stored words survive the reset.
- R9: With the read enable inactive, `rdData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock, rising edge |
| rdClk | input | 1 | Read clock, rising edge |
| rstN | input | 1 | Active-low reset of the output path |
| wrShape | input | 2 | Write-port shape code |
| rdShape | input | 2 | Read-port shape code |
| wrEn | input | 1 | Write enable, polarity set by WR_EN_HIGH |
| rdEn | input | 1 | Read enable, polarity set by RD_EN_HIGH |
| pipeSel | input | 1 | High adds one output register stage |
| wrAddr | input | 9 | Write address |
| rdAddr | input | 9 | Read address |
| wrData | input | 18 | Write data |
| rdData | output | 18 | Read data |

## Verification
A wrong bank select or a wrong index shows on the next read of the affected words, and on no other read. Reading words back in the opposite shape exposes such a fault, because the two halves come back swapped or land in the wrong word. A fault in the output registers shows at once: a hold that should keep `rdData` lets it move, or a pipelined read shows its data one `rdClk` edge too early or too late. A write that gets through during reset or with a reserved code stays hidden until that word is read, so the bench reads it back straight after the reset ends.

// File: rtl/ram_pkg.sv
package ram_pkg;
  localparam int NARROW_W = 9;
  localparam int WIDE_W   = 2 * NARROW_W;
  localparam int ADDR_W   = 9;
  localparam int IDX_W    = ADDR_W - 1;
  localparam int BANK_D   = 1 << IDX_W;

  typedef enum logic [1:0] {
    SHAPE_RSVD_LO = 2'b00,
    SHAPE_NARROW  = 2'b01,
    SHAPE_WIDE    = 2'b10,
    SHAPE_RSVD_HI = 2'b11
  } shape_e;

  typedef struct packed {
    logic [1:0]       bankWe;
    logic             wide;
    logic [IDX_W-1:0] idx;
  } wr_strobe_t;

  typedef struct packed {
    logic             load;
    logic             wide;
    logic             selHi;
    logic [IDX_W-1:0] idx;
  } rd_strobe_t;
endpackage

// File: rtl/ram_ctrl.sv
module ram_ctrl
  import ram_pkg::*;
#(
  parameter bit WR_EN_HIGH = 1'b0,
  parameter bit RD_EN_HIGH = 1'b0
) (
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        wrShape,
  input  logic [1:0]        rdShape,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output wr_strobe_t        wrStb,
  output rd_strobe_t        rdStb
);
  logic wrOn;
  logic rdOn;

  assign wrOn = rstN && (WR_EN_HIGH ? wrEn : !wrEn);
  assign rdOn = rstN && (RD_EN_HIGH ? rdEn : !rdEn);

  always_comb begin
    wrStb     = '0;
    wrStb.idx = wrAddr[ADDR_W-1:1];
    case (shape_e'(wrShape))
      SHAPE_NARROW: begin
        wrStb.bankWe[wrAddr[0]] = wrOn;
      end
      SHAPE_WIDE: begin
        wrStb.wide   = 1'b1;
        wrStb.idx    = wrAddr[IDX_W-1:0];
        wrStb.bankWe = {2{wrOn}};
      end
      default: wrStb.bankWe = 2'b00;
    endcase
  end

  always_comb begin
    rdStb       = '0;
    rdStb.idx   = rdAddr[ADDR_W-1:1];
    rdStb.selHi = rdAddr[0];
    case (shape_e'(rdShape))
      SHAPE_NARROW: rdStb.load = rdOn;
      SHAPE_WIDE: begin
        rdStb.wide = 1'b1;
        rdStb.idx  = rdAddr[IDX_W-1:0];
        rdStb.load = rdOn;
      end
      default: rdStb.load = 1'b0;
    endcase
  end
endmodule

// File: rtl/ram_datapath.sv
module ram_datapath
  import ram_pkg::*;
(
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              pipeSel,
  input  logic [WIDE_W-1:0] wrData,
  input  wr_strobe_t        wrStb,
  input  rd_strobe_t        rdStb,
  output logic [WIDE_W-1:0] rdData
);
  logic [1:0][NARROW_W-1:0] bankRd;
  logic [WIDE_W-1:0]        rdWord;
  logic [WIDE_W-1:0]        outStage;
  logic [WIDE_W-1:0]        pipeStage;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [NARROW_W-1:0] mem [BANK_D];
    logic [NARROW_W-1:0] bankIn;

    assign bankIn = wrStb.wide ? wrData[b*NARROW_W +: NARROW_W] : wrData[NARROW_W-1:0];

    always_ff @(posedge wrClk) begin
      if (wrStb.bankWe[b]) mem[wrStb.idx] <= bankIn;
    end

    assign bankRd[b] = mem[rdStb.idx];
  end

  always_comb begin
    if (rdStb.wide) rdWord = {bankRd[1], bankRd[0]};
    else            rdWord = {{NARROW_W{1'b0}}, bankRd[rdStb.selHi]};
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      outStage  <= '0;
      pipeStage <= '0;
    end else begin
      if (rdStb.load) outStage <= rdWord;
      pipeStage <= outStage;
    end
  end

  assign rdData = pipeSel ? pipeStage : outStage;
endmodule

// File: rtl/dual_shape_ram.sv
module dual_shape_ram
  import ram_pkg::*;
#(
  parameter bit WR_EN_HIGH = 1'b0,
  parameter bit RD_EN_HIGH = 1'b0
) (
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        rstN,
  input  logic [1:0]  wrShape,
  input  logic [1:0]  rdShape,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        pipeSel,
  input  logic [8:0]  wrAddr,
  input  logic [8:0]  rdAddr,
  input  logic [17:0] wrData,
  output logic [17:0] rdData
);
  wr_strobe_t wrStb;
  rd_strobe_t rdStb;

  ram_ctrl #(
    .WR_EN_HIGH(WR_EN_HIGH),
    .RD_EN_HIGH(RD_EN_HIGH)
  ) u_ctrl (
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .wrShape(wrShape),
    .rdShape(rdShape),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .wrStb  (wrStb),
    .rdStb  (rdStb)
  );

  ram_datapath u_dp (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .rstN   (rstN),
    .pipeSel(pipeSel),
    .wrData (wrData),
    .wrStb  (wrStb),
    .rdStb  (rdStb),
    .rdData (rdData)
  );
endmodule

// File: rtl/dual_shape_ram_checker.sv
module dual_shape_ram_checker #(
  parameter bit RD_EN_HIGH = 1'b0
) (
  input logic        rdClk,
  input logic        rstN,
  input logic [1:0]  rdShape,
  input logic        rdEn,
  input logic        pipeSel,
  input logic [17:0] rdData
);
  logic rdActive;
  logic rdNarrow;

  assign rdActive = (RD_EN_HIGH ? rdEn : !rdEn) && (rdShape == 2'b01 || rdShape == 2'b10);
  assign rdNarrow = (RD_EN_HIGH ? rdEn : !rdEn) && rdShape == 2'b01;

  AST_RESET_ZERO: assert property (@(posedge rdClk) !rstN |-> rdData == 18'd0); // R8

  AST_IDLE_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    (!rdActive && !pipeSel) |=> (pipeSel || $stable(rdData))); // R9

  AST_PIPE_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    (!rdActive && $past(!rdActive) && pipeSel) |=> (!pipeSel || $stable(rdData))); // R5

  AST_NARROW_UPPER: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdNarrow && !pipeSel) |=> (pipeSel || rdData[17:9] == 9'd0)); // R4
endmodule

bind dual_shape_ram dual_shape_ram_checker #(.RD_EN_HIGH(RD_EN_HIGH)) u_checker (
  .rdClk  (rdClk),
  .rstN   (rstN),
  .rdShape(rdShape),
  .rdEn   (rdEn),
  .pipeSel(pipeSel),
  .rdData (rdData)
);

// File: tb/test_dual_shape_ram.sv
module test_dual_shape_ram;
  logic        wrClk = 1'b0;
  logic        rdClk = 1'b0;
  logic        rstN  = 1'b0;
  logic [1:0]  wrShape = 2'b01;
  logic [1:0]  rdShape = 2'b01;
  logic        wrEnN = 1'b1;
  logic        rdEnN = 1'b1;
  logic        wrEnH = 1'b0;
  logic        rdEnH = 1'b0;
  logic        pipeSel = 1'b0;
  logic [8:0]  wrAddr = '0;
  logic [8:0]  rdAddr = '0;
  logic [17:0] wrData = '0;
  logic [17:0] rdDataL;
  logic [17:0] rdDataH;

  logic [8:0] refMem [512];
  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #2 wrClk = ~wrClk;
  always #3 rdClk = ~rdClk;

  dual_shape_ram i_dual_shape_ram (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrShape(wrShape), .rdShape(rdShape),
    .wrEn(wrEnN), .rdEn(rdEnN), .pipeSel(pipeSel),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .rdData(rdDataL)
  );

  dual_shape_ram #(.WR_EN_HIGH(1'b1), .RD_EN_HIGH(1'b1)) i_dual_shape_ram_hi (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrShape(wrShape), .rdShape(rdShape),
    .wrEn(wrEnH), .rdEn(rdEnH), .pipeSel(pipeSel),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .rdData(rdDataH)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] expNarrow(input logic [8:0] a);
    return {9'd0, refMem[a]};
  endfunction

  function automatic logic [17:0] expWide(input logic [8:0] a);
    return {refMem[{a[7:0], 1'b1}], refMem[{a[7:0], 1'b0}]};
  endfunction

  task automatic doWrite(input logic [1:0] shp, input logic [8:0] a, input logic [17:0] d, input bit hi);
    @(negedge wrClk);
    wrShape = shp; wrAddr = a; wrData = d;
    if (hi) wrEnH = 1'b1; else wrEnN = 1'b0;
    @(negedge wrClk);
    wrEnN = 1'b1; wrEnH = 1'b0;
    if (!hi && rstN) begin
      if (shp == 2'b01) refMem[a] = d[8:0];
      if (shp == 2'b10) begin
        refMem[{a[7:0], 1'b0}] = d[8:0];
        refMem[{a[7:0], 1'b1}] = d[17:9];
      end
    end
  endtask

  task automatic doRead(input logic [1:0] shp, input logic [8:0] a, input bit hi);
    @(negedge rdClk);
    rdShape = shp; rdAddr = a;
    if (hi) rdEnH = 1'b1; else rdEnN = 1'b0;
    @(negedge rdClk);
    rdEnN = 1'b1; rdEnH = 1'b0;
    if (pipeSel) @(negedge rdClk);
  endtask

  task automatic tReset;
    chk("R8 reset output", rdDataL, 18'd0);
    chk("R8 reset output hi", rdDataH, 18'd0);
  endtask

  task automatic tNarrow;
    doWrite(2'b01, 9'd0,   18'h000AA, 1'b0);
    doWrite(2'b01, 9'd1,   18'h00155, 1'b0);
    doWrite(2'b01, 9'd511, 18'h3FF1F, 1'b0);
    doWrite(2'b01, 9'd200, 18'h00123, 1'b0);
    doRead(2'b01, 9'd0, 1'b0);   chk("R1 R2 narrow addr0", rdDataL, expNarrow(9'd0));
    doRead(2'b01, 9'd511, 1'b0); chk("R4 narrow upper zero", rdDataL, expNarrow(9'd511));
    doRead(2'b01, 9'd200, 1'b0); chk("R2 narrow addr200", rdDataL, expNarrow(9'd200));
  endtask

  task automatic tWide;
    doRead(2'b10, 9'd0, 1'b0); chk("R3 wide over narrow pair", rdDataL, expWide(9'd0));
    doWrite(2'b10, 9'd5, 18'h2ABCD, 1'b0);
    doRead(2'b01, 9'd10, 1'b0); chk("R3 low half at 2n", rdDataL, expNarrow(9'd10));
    doRead(2'b01, 9'd11, 1'b0); chk("R3 high half at 2n+1", rdDataL, expNarrow(9'd11));
    doWrite(2'b10, 9'h105, 18'h12345, 1'b0);
    doRead(2'b10, 9'd5, 1'b0); chk("R2 wide addr bit8 ignored", rdDataL, 18'h12345);
    doRead(2'b10, 9'h105, 1'b0); chk("R2 wide read addr bit8 ignored", rdDataL, 18'h12345);
  endtask

  task automatic tPipe;
    logic [17:0] prev;
    @(negedge rdClk); pipeSel = 1'b1;
    repeat (2) @(negedge rdClk);
    prev = rdDataL;
    rdShape = 2'b10; rdAddr = 9'd0; rdEnN = 1'b0;
    @(negedge rdClk); rdEnN = 1'b1;
    chk("R5 pipe output unchanged after first edge", rdDataL, prev);
    @(negedge rdClk);
    chk("R5 pipe data after second edge", rdDataL, expWide(9'd0));
    doRead(2'b01, 9'd200, 1'b0); chk("R5 pipe narrow read", rdDataL, expNarrow(9'd200));
    @(negedge rdClk); pipeSel = 1'b0;
  endtask

  task automatic tReserved;
    logic [17:0] prev;
    doWrite(2'b00, 9'd10, 18'h00077, 1'b0);
    doWrite(2'b11, 9'd11, 18'h00066, 1'b0);
    doRead(2'b10, 9'd5, 1'b0); chk("R7 reserved writes ignored", rdDataL, expWide(9'd5));
    prev = rdDataL;
    doRead(2'b11, 9'd0, 1'b0); chk("R7 reserved read holds", rdDataL, prev);
    doRead(2'b00, 9'd200, 1'b0); chk("R7 reserved read holds 00", rdDataL, prev);
  endtask

  task automatic tDisabled;
    logic [17:0] prev;
    prev = rdDataL;
    @(negedge rdClk); rdShape = 2'b01; rdAddr = 9'd1;
    repeat (3) @(negedge rdClk);
    chk("R9 disabled read holds", rdDataL, prev);
  endtask

  task automatic tResetKeep;
    @(negedge wrClk); rstN = 1'b0;
    #1 chk("R8 output zero during reset", rdDataL, 18'd0);
    doWrite(2'b01, 9'd0, 18'h00011, 1'b0);
    @(negedge wrClk); rstN = 1'b1;
    doRead(2'b01, 9'd0, 1'b0); chk("R8 contents kept, write blocked", rdDataL, expNarrow(9'd0));
    doRead(2'b01, 9'd511, 1'b0); chk("R8 contents kept", rdDataL, expNarrow(9'd511));
  endtask

  task automatic tPolarity;
    doWrite(2'b01, 9'h020, 18'h00033, 1'b0);
    doWrite(2'b01, 9'h020, 18'h000A5, 1'b1);
    doRead(2'b01, 9'h020, 1'b1); chk("R6 active-high write and read", rdDataH, 18'h000A5);
    doRead(2'b01, 9'h020, 1'b0); chk("R6 low-active copy untouched", rdDataL, expNarrow(9'h020));
  endtask

  initial begin
    #800000;
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge rdClk);
    tReset();
    @(negedge wrClk); rstN = 1'b1;
    tNarrow();
    tWide();
    tPipe();
    tReserved();
    tDisabled();
    tResetKeep();
    tPolarity();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule